// File: doc/BRIEF.md
# Legacy Modem PHY Bit Encoder

This block turns a stream of bytes into the line bit stream of a simple narrowband FSK data link. Bytes enter through a valid/ready handshake. Each byte is sent as eight bits, least-significant bit first. Every bit passes through a seven-stage self-synchronizing scrambler and then an NRZI differential encoder. One line bit leaves per cycle in which the bit-clock enable is high. The FSK modulator that follows samples the line level.

After reset the encoder first sends a run of priming 0xFF bytes. These fill the far-end descrambler with ones so that it is in a known state. Once a programmable number of payload bytes has been sent in a row, a 0x7E sync character is inserted. Whenever no byte is offered at a byte boundary, 0x7E idle characters fill the gap, so the line never falls silent. The far-end receiver discards 0x7E characters, so inserted and idle characters do not change the delivered payload. The sync and idle characters go through the scrambler and encoder exactly like payload. The scrambler uses the polynomial 1 + x^5 + x^7, which is not primitive. It feeds back its own output bits and starts from all ones.

Top module: `lmod_bit_encoder`

## Requirements
- R1: While reset is held, `line_out` is 0 and `in_ready` is 0. The scrambler history starts at all ones.
- R2: Each cycle with `bit_en` high emits exactly one line bit. In a cycle with `bit_en` low, `line_out` keeps its level.
- R3: Every character is eight bits long and is sent least-significant bit first.
- R4: The scrambled bit is the data bit XORed with the scrambled bits sent 5 and 7 positions earlier. Each scrambled bit is shifted into the history.
- R5: NRZI coding sends a scrambled 1 as no change of `line_out` and a scrambled 0 as a toggle of `line_out`.
- R6: After reset, PRIME_BYTES bytes of 0xFF are sent before any payload. `in_ready` stays 0 during these bytes.
- R7: `in_ready` is high only in a cycle that has `bit_en` high and starts a new byte, and only when that byte slot is free for payload. A byte is taken when `in_valid` and `in_ready` are both high.
- R8: When `sync_every` = N is nonzero, a 0x7E byte is sent after every N payload bytes sent in a row. During that byte `in_ready` stays 0. When N = 0, no such byte is inserted.
- R9: At a byte boundary with no byte offered, a 0x7E idle byte is sent. Any 0x7E byte restarts the count of payload bytes used by R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| sync_every | input | SYNC_W | Payload bytes between inserted 0x7E bytes; 0 disables insertion |
| in_ready | output | 1 | Offered byte is taken in this cycle |
| line_out | output | 1 | NRZI line level |

## Verification
The hardest case to reach is the point where a byte boundary, a due sync insertion and a missing payload byte coincide. At that point the choice between sync, idle and payload byte decides both the handshake and the next count. The bench reaches it by sweeping every insertion interval from 0 to 3, by gating `bit_en` irregularly, and by withholding `in_valid` on every fourth byte slot. It recovers the bytes from `line_out` with its own NRZI decoder and descrambler. It then compares the recovered bytes and every `in_ready` value with a byte schedule derived from the requirements.

// File: rtl/lmod_bit_encoder.sv
module lmod_bit_encoder #(
  parameter int SYNC_W      = 4,
  parameter int PRIME_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic [SYNC_W-1:0] sync_every,
  output logic              in_ready,
  output logic              line_out
);
  localparam int PW = $clog2(PRIME_BYTES + 2);
  localparam logic [7:0] FILL_CH  = 8'h7E;
  localparam logic [7:0] PRIME_CH = 8'hFF;

  logic [6:0]        sh;
  logic [2:0]        cnt;
  logic [PW-1:0]     prime_left;
  logic [SYNC_W-1:0] pay_cnt;
  logic [6:0]        scr;
  logic              line;

  wire at_start = (cnt == 3'd0);
  wire priming  = (prime_left != '0);
  wire sync_due = (sync_every != '0) && (pay_cnt == sync_every);
  wire take     = in_ready && in_valid;

  assign in_ready = bit_en && at_start && !priming && !sync_due;

  wire [7:0] sel  = priming ? PRIME_CH : (take ? in_data : FILL_CH);
  wire       dbit = at_start ? sel[0] : sh[0];
  wire       sbit = dbit ^ scr[4] ^ scr[6];

  assign line_out = line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= '0;
      cnt        <= '0;
      prime_left <= PRIME_BYTES[PW-1:0];
      pay_cnt    <= '0;
      scr        <= '1;
      line       <= 1'b0;
    end else if (bit_en) begin
      cnt  <= cnt + 3'd1;
      scr  <= {scr[5:0], sbit};
      line <= sbit ? line : ~line;
      if (at_start) begin
        sh <= sel[7:1];
        if (priming)   prime_left <= prime_left - 1'b1;
        else if (take) pay_cnt    <= pay_cnt + 1'b1;
        else           pay_cnt    <= '0;
      end else begin
        sh <= {1'b0, sh[6:1]};
      end
    end
  end
endmodule

// File: rtl/lmod_bit_encoder_chk.sv
module lmod_bit_encoder_chk #(
  parameter int SYNC_W      = 4,
  parameter int PRIME_BYTES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              in_valid,
  input logic [SYNC_W-1:0] sync_every,
  input logic              in_ready,
  input logic              line_out
);
  logic [2:0]      ck_cnt;
  int unsigned     ck_bytes;
  logic [SYNC_W:0] ck_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_cnt   <= '0;
      ck_bytes <= 0;
      ck_run   <= '0;
    end else if (bit_en) begin
      ck_cnt <= ck_cnt + 3'd1;
      if (ck_cnt == 3'd0) begin
        if (ck_bytes <= PRIME_BYTES) ck_bytes <= ck_bytes + 1;
        ck_run <= (in_ready && in_valid) ? ck_run + 1'b1 : '0;
      end
    end
  end

  p_reset_line_r1: assert property (@(posedge clk) !rst_n |=> (!line_out || !rst_n));

  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out));

  p_prime_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_bytes < PRIME_BYTES) |-> !in_ready);

  p_ready_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && ck_cnt == 3'd0));

  p_sync_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_every != '0) |-> (ck_run <= {1'b0, sync_every}));
endmodule

bind lmod_bit_encoder lmod_bit_encoder_chk #(.SYNC_W(SYNC_W), .PRIME_BYTES(PRIME_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
  .sync_every(sync_every), .in_ready(in_ready), .line_out(line_out));

// File: tb/lmod_bit_encoder_bench.sv
`timescale 1ns/1ps
module lmod_bit_encoder_bench;
  localparam int SYNC_W = 4;
  localparam int PRIME  = 2;
  localparam int NPAY   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [SYNC_W-1:0] sync_every = '0;
  logic in_ready, line_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lmod_bit_encoder #(.SYNC_W(SYNC_W), .PRIME_BYTES(PRIME)) u_lmod_bit_encoder (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid), .in_data(in_data),
    .sync_every(sync_every), .in_ready(in_ready), .line_out(line_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) begin
      logic [7:0] exp_q [0:255];
      logic [7:0] pay   [0:NPAY-1];
      int wr, rd, k, pl, pc, bcnt, slot, bpos, cyc;
      logic lvl, prev_en;
      logic [6:0] dr;
      logic [7:0] acc;

      for (int i = 0; i < NPAY; i++) pay[i] = 8'((n * 53 + i * 29 + 1) & 255);
      wr = 0; rd = 0; k = 0; pl = PRIME; pc = 0; bcnt = 0; slot = 0; bpos = 0; cyc = 0;
      lvl = 1'b0; prev_en = 1'b0; dr = '1; acc = '0;

      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; sync_every = SYNC_W'(n);
      repeat (3) @(negedge clk);
      check(line_out == 1'b0 && in_ready == 1'b0, "R1 reset outputs", {line_out, in_ready}, 0);
      rst_n = 1'b1;

      while (cyc < 3000 && !(k == NPAY && rd >= wr && rd > PRIME + NPAY + 2)) begin
        logic en, val, exp_rdy;
        @(negedge clk);
        cyc++;
        if (prev_en) begin
          logic s, d;
          s = (line_out == lvl);
          lvl = line_out;
          d = s ^ dr[4] ^ dr[6];
          dr = {dr[5:0], s};
          acc[bpos] = d;
          bpos++;
          if (bpos == 8) begin
            bpos = 0;
            check(rd < wr && acc == exp_q[rd[7:0]], "R3 R4 R5 recovered byte", acc,
                  rd < wr ? exp_q[rd[7:0]] : 0);
            rd++;
          end
        end else if (cyc > 1) begin
          check(line_out == lvl, "R2 line held without bit_en", line_out, lvl);
        end

        en  = (n[0] == 1'b1) ? ((cyc % 3) != 2) : 1'b1;
        val = (k < NPAY) && ((slot % 4) != 2);
        bit_en = en; in_valid = val; in_data = (k < NPAY) ? pay[k] : 8'h00;
        #0.5;
        exp_rdy = en && bcnt == 0 && pl == 0 && !(n != 0 && pc == n);
        if (en && bcnt == 0) begin
          check(in_ready == exp_rdy, "R6 R7 R8 ready at boundary", in_ready, exp_rdy);
          if (pl > 0) begin
            exp_q[wr[7:0]] = 8'hFF; pl--;
          end else if (exp_rdy && val) begin
            exp_q[wr[7:0]] = pay[k]; k++; pc++;
          end else begin
            exp_q[wr[7:0]] = 8'h7E; pc = 0;
          end
          wr++;
          slot++;
        end else begin
          check(in_ready == 1'b0, "R7 ready low mid-byte", in_ready, 0);
        end
        if (en) bcnt = (bcnt + 1) % 8;
        prev_en = en;
      end
      check(k == NPAY, "R9 all payload delivered", k, NPAY);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule